// File: doc/BRIEF.md
# PCI Inbound Window BAR Aliasing

This block holds the configuration-space base address registers (BARs) for three inbound windows into local memory. Each window also has a local base register and an attribute register, and both can be reached from the local CSR port. The attribute register holds a 5-bit size field and a prefetch-enable flag.

A configuration write to a BAR changes only the base address bits that the window size leaves writable. Those same bits land in the window's local base register, because both views share one stored value. A BAR read shows the writable bits of that value, the prefetch flag in bit 3, and zeros everywhere else.

Both read paths are combinational. A change to the size or prefetch field therefore shows on the very next BAR read. When a configuration write and a local write hit the same window base in one cycle, the local write wins.

Top module: `pci_win_bar`

## Requirements
- R1: After reset, every BAR reads 0, and every local base and attribute register reads 0.
- R2: BAR read bits 11:4 are always 0. Bits 2:1 (type) and bit 0 (space indicator) are always 0, and writes to them are ignored.
- R3: BAR read bit 3 equals the prefetch-enable bit (attribute bit 8) of the same window, in the same cycle that bit is read.
- R4: The size field is attribute bits 4:0. A value n from 11 to 31 makes base bits n and below non-writable, and a value below 11 acts as 11. A configuration write to a BAR changes only the writable bits among 31:12.
- R5: Non-writable base bits keep their earlier value on a configuration write, which a local base read shows. A BAR read returns them as 0.
- R6: A configuration write to a BAR updates the same writable bits in the window's local base register. The local base register reads bits 31:12 and returns 0 in bits 11:0.
- R7: Configuration byte enables (bit j covers data bits 8j+7:8j) limit a write to the enabled bytes, and the size mask still applies.
- R8: If a local base write and a configuration BAR write hit the same window in the same cycle, the local value is stored and the configuration data is dropped.
- R9: A change to a size or prefetch field is visible on the BAR read path in the cycle after the local write, with no extra latency.
- R10: The BARs sit at configuration byte offsets 0x14, 0x18 and 0x1C for windows 0, 1 and 2. Any other configuration offset reads 0 and its writes change nothing.
- R11: Local map: the base of window i is at offset 8*i and its attribute register at 8*i+4. Unused attribute bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgAddr | input | 8 | Configuration byte offset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgBe | input | 4 | Configuration byte enables |
| cfgWdata | input | 32 | Configuration write data |
| cfgRdata | output | 32 | Configuration read data (combinational) |
| csrAddr | input | 8 | Local CSR byte offset |
| csrWe | input | 1 | Local CSR write strobe |
| csrWdata | input | 32 | Local CSR write data |
| csrRdata | output | 32 | Local CSR read data (combinational) |

## Verification
A configuration BAR write and a local base write can land on the same window in one cycle. The bench provokes this with directed cases and also lets random traffic produce it, driving both ports on the same edge. In each such cycle the local base read must show the local data, masked to bits 31:12, with no trace of the configuration data. A collision on different windows must apply both writes. The same cycle-level comparison covers a size change on one port while the other port reads the BAR.

// File: rtl/pci_win_bar_pkg.sv
package pci_win_bar_pkg;
  localparam int WIN_CNT = 3;
  localparam int SIZE_W = 5;
  localparam int PF_BIT = 8;
  localparam int MIN_SIZE = 11;

  typedef struct packed {
    logic [WIN_CNT-1:0] cfgSel;
    logic [WIN_CNT-1:0] cfgWr;
    logic [WIN_CNT-1:0] csrBaseSel;
    logic [WIN_CNT-1:0] csrAttrSel;
    logic [WIN_CNT-1:0] csrBaseWr;
    logic [WIN_CNT-1:0] csrAttrWr;
  } winStrobe_t;

  function automatic logic [31:0] writableMask(input logic [SIZE_W-1:0] sz);
    logic [31:0] m;
    int eff;
    eff = (int'(sz) < MIN_SIZE) ? MIN_SIZE : int'(sz);
    for (int k = 0; k < 32; k++) m[k] = (k > eff);
    return m;
  endfunction

  function automatic logic [31:0] byteMask(input logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction
endpackage

// File: rtl/pci_win_bar_ctrl.sv
module pci_win_bar_ctrl
  import pci_win_bar_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BAR_OFF0 = 8'h14,
  parameter int CSR_STRIDE = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic cfgWe,
  input  logic [ADDR_W-1:0] csrAddr,
  input  logic csrWe,
  output winStrobe_t strobe
);
  always_comb begin
    strobe = '0;
    for (int i = 0; i < WIN_CNT; i++) begin
      strobe.cfgSel[i] = (cfgAddr == ADDR_W'(int'(BAR_OFF0) + 4 * i));
      strobe.csrBaseSel[i] = (csrAddr == ADDR_W'(CSR_STRIDE * i));
      strobe.csrAttrSel[i] = (csrAddr == ADDR_W'(CSR_STRIDE * i + 4));
      strobe.csrBaseWr[i] = csrWe && strobe.csrBaseSel[i];
      strobe.csrAttrWr[i] = csrWe && strobe.csrAttrSel[i];
      // the local port takes priority over the configuration port
      strobe.cfgWr[i] = cfgWe && strobe.cfgSel[i] && !strobe.csrBaseWr[i];
    end
  end

  AST_CFG_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe.cfgWr)); // R10
  AST_NO_DUAL_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.cfgWr & strobe.csrBaseWr) == '0); // R8
endmodule

// File: rtl/pci_win_bar_dp.sv
module pci_win_bar_dp
  import pci_win_bar_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  winStrobe_t strobe,
  input  logic [3:0] cfgBe,
  input  logic [31:0] cfgWdata,
  input  logic [31:0] csrWdata,
  output logic [31:0] cfgRdata,
  output logic [31:0] csrRdata
);
  logic [31:0] baseQ [WIN_CNT];
  logic [SIZE_W-1:0] sizeQ [WIN_CNT];
  logic pfQ [WIN_CNT];
  logic [31:0] wrMask [WIN_CNT];
  logic [31:0] barView [WIN_CNT];

  for (genvar i = 0; i < WIN_CNT; i++) begin : gWin
    assign wrMask[i] = writableMask(sizeQ[i]);
    assign barView[i] = (baseQ[i] & wrMask[i]) | (32'(pfQ[i]) << 3);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        baseQ[i] <= '0;
        sizeQ[i] <= '0;
        pfQ[i] <= 1'b0;
      end else begin
        if (strobe.csrBaseWr[i])
          baseQ[i] <= csrWdata & 32'hFFFF_F000;
        else if (strobe.cfgWr[i])
          baseQ[i] <= (baseQ[i] & ~(wrMask[i] & byteMask(cfgBe)))
                    | (cfgWdata & wrMask[i] & byteMask(cfgBe));
        if (strobe.csrAttrWr[i]) begin
          sizeQ[i] <= csrWdata[SIZE_W-1:0];
          pfQ[i] <= csrWdata[PF_BIT];
        end
      end
    end

    AST_MASKED_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.cfgWr[i] && !strobe.csrBaseWr[i]) |=>
        ((baseQ[i] & ~$past(wrMask[i])) == ($past(baseQ[i]) & ~$past(wrMask[i])))); // R5
    AST_CSR_WINS: assert property (@(posedge clk) disable iff (!rstN)
      strobe.csrBaseWr[i] |=> (baseQ[i] == ($past(csrWdata) & 32'hFFFF_F000))); // R8
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
      (!strobe.cfgWr[i] && !strobe.csrBaseWr[i]) |=> $stable(baseQ[i])); // R10
  end

  always_comb begin
    cfgRdata = '0;
    csrRdata = '0;
    for (int i = 0; i < WIN_CNT; i++) begin
      if (strobe.cfgSel[i]) cfgRdata |= barView[i];
      if (strobe.csrBaseSel[i]) csrRdata |= baseQ[i];
      if (strobe.csrAttrSel[i])
        csrRdata |= (32'(pfQ[i]) << PF_BIT) | 32'(sizeQ[i]);
    end
  end

  AST_FIXED_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRdata[11:4] == '0) && (cfgRdata[2:0] == '0)); // R2
endmodule

// File: rtl/pci_win_bar.sv
module pci_win_bar
  import pci_win_bar_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BAR_OFF0 = 8'h14,
  parameter int CSR_STRIDE = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic cfgWe,
  input  logic [3:0] cfgBe,
  input  logic [31:0] cfgWdata,
  output logic [31:0] cfgRdata,
  input  logic [ADDR_W-1:0] csrAddr,
  input  logic csrWe,
  input  logic [31:0] csrWdata,
  output logic [31:0] csrRdata
);
  winStrobe_t strobe;

  pci_win_bar_ctrl #(.ADDR_W(ADDR_W), .BAR_OFF0(BAR_OFF0), .CSR_STRIDE(CSR_STRIDE)) uCtrl (
    .clk(clk), .rstN(rstN), .cfgAddr(cfgAddr), .cfgWe(cfgWe),
    .csrAddr(csrAddr), .csrWe(csrWe), .strobe(strobe)
  );

  pci_win_bar_dp uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgBe(cfgBe),
    .cfgWdata(cfgWdata), .csrWdata(csrWdata),
    .cfgRdata(cfgRdata), .csrRdata(csrRdata)
  );
endmodule

// File: tb/tb_pci_win_bar.sv
module tb_pci_win_bar;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] cfgAddr = '0, csrAddr = '0;
  logic cfgWe = 1'b0, csrWe = 1'b0;
  logic [3:0] cfgBe = '0;
  logic [31:0] cfgWdata = '0, csrWdata = '0;
  logic [31:0] cfgRdata, csrRdata;

  int checks = 0;
  int failures = 0;
  logic [31:0] mBase [NW];
  logic [4:0] mSize [NW];
  logic mPf [NW];

  pci_win_bar dut (.*);

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [31:0] expMask(input logic [4:0] sz);
    logic [31:0] m = '0;
    int eff = (sz < 11) ? 11 : int'(sz);
    for (int k = eff + 1; k < 32; k++) m[k] = 1'b1;
    return m;
  endfunction

  function automatic logic [31:0] expBar(input int w);
    return (mBase[w] & expMask(mSize[w])) | (mPf[w] ? 32'h8 : 32'h0);
  endfunction

  function automatic logic [31:0] beMask(input logic [3:0] be);
    logic [31:0] m;
    for (int j = 0; j < 4; j++) m[8*j +: 8] = {8{be[j]}};
    return m;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one cycle with optional writes on both ports, then update the model
  task automatic cycle(input logic cw, input logic [7:0] ca, input logic [3:0] be,
                       input logic [31:0] cd, input logic lw, input logic [7:0] la,
                       input logic [31:0] ld);
    @(negedge clk);
    cfgWe = cw; cfgAddr = ca; cfgBe = be; cfgWdata = cd;
    csrWe = lw; csrAddr = la; csrWdata = ld;
    @(posedge clk);
    #1;
    for (int w = 0; w < NW; w++) begin
      logic localBase = lw && (la == 8'(8 * w));
      if (localBase) mBase[w] = ld & 32'hFFFF_F000;
      else if (cw && ca == 8'(8'h14 + 4 * w)) begin
        logic [31:0] m = expMask(mSize[w]) & beMask(be);
        mBase[w] = (mBase[w] & ~m) | (cd & m);
      end
      if (lw && la == 8'(8 * w + 4)) begin
        mSize[w] = ld[4:0];
        mPf[w] = ld[8];
      end
    end
    cfgWe = 1'b0; csrWe = 1'b0;
  endtask

  task automatic readBar(input string req, input int w);
    cfgAddr = 8'(8'h14 + 4 * w); #1;
    check(req, cfgRdata, expBar(w));
  endtask

  task automatic readLocal(input string req, input int w, input bit attr);
    csrAddr = 8'(8 * w + (attr ? 4 : 0)); #1;
    check(req, csrRdata, attr ? ((mPf[w] ? 32'h100 : 32'h0) | 32'(mSize[w])) : mBase[w]);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int w = 0; w < NW; w++) begin mBase[w] = '0; mSize[w] = '0; mPf[w] = 1'b0; end
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    #2;
    // R1 reset values
    for (int w = 0; w < NW; w++) begin
      readBar("R1", w); readLocal("R1", w, 0); readLocal("R1", w, 1);
    end
    // R4 R2 size below minimum: bits 31:12 writable, low bits ignored
    cycle(1, 8'h14, 4'hF, 32'hFFFF_FFFF, 0, 8'h0, 0);
    readBar("R4", 0);
    check("R2", cfgRdata & 32'h0000_0FFF, 32'h0);
    // R3 R9 prefetch and size change visible immediately
    cycle(0, 8'h14, 4'h0, 0, 1, 8'h04, 32'h0000_0114);
    readBar("R9", 0);
    check("R3", cfgRdata[3], 1'b1);
    // R5 masked bits held locally, zero on BAR
    cycle(1, 8'h14, 4'hF, 32'h0000_0000, 0, 8'h0, 0);
    readBar("R5", 0); readLocal("R5", 0, 0);
    check("R5", csrRdata & 32'h001F_F000, 32'h001F_F000);
    // R4 size 31: nothing writable
    cycle(0, 8'h0, 4'h0, 0, 1, 8'h0C, 32'h1F);
    cycle(1, 8'h18, 4'hF, 32'hABCD_E000, 0, 8'h0, 0);
    readBar("R4", 1); readLocal("R4", 1, 0);
    // R6 R7 partial byte write mirrored
    cycle(0, 8'h0, 4'h0, 0, 1, 8'h14, 32'h0C);
    cycle(1, 8'h1C, 4'b0100, 32'h5A5A_5000, 0, 8'h0, 0);
    readLocal("R6", 2, 0); readBar("R7", 2);
    // R8 collision same window: local wins
    cycle(1, 8'h1C, 4'hF, 32'hFFFF_F000, 1, 8'h10, 32'h1234_5FFF);
    readLocal("R8", 2, 0); readBar("R8", 2);
    // R8 collision different windows: both apply
    cycle(1, 8'h14, 4'hF, 32'hF0F0_F000, 1, 8'h10, 32'h0000_1000);
    readBar("R8", 0); readLocal("R8", 2, 0);
    // R10 unmapped offset
    cycle(1, 8'h10, 4'hF, 32'hFFFF_FFFF, 0, 8'h0, 0);
    cfgAddr = 8'h10; #1; check("R10", cfgRdata, 32'h0);
    for (int w = 0; w < NW; w++) readBar("R10", w);
    // R11 attr unused bits read zero
    cycle(0, 8'h0, 4'h0, 0, 1, 8'h04, 32'hFFFF_FFFF);
    readLocal("R11", 0, 1);
    // random mix of both ports
    for (int n = 0; n < 400; n++) begin
      logic [7:0] ca = 8'(8'h10 + 4 * ($urandom % 5));
      logic [7:0] la = 8'(4 * ($urandom % 7));
      cycle($urandom % 2, ca, 4'($urandom), $urandom, $urandom % 2, la, $urandom);
      for (int w = 0; w < NW; w++) begin
        readBar("R4", w); readLocal("R6", w, 0); readLocal("R11", w, 1);
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule